// File: doc/BRIEF.md
# Z80 Subsystem Bus Controller

This block sits on the 68000 host bus and turns host byte and word accesses that land in the sound-subsystem address area into one-cycle select strobes for the shared Z80 RAM, the FM unit, the PSG and the I/O-port block. Host reads of those targets come back two cycles after the request. RAM reads return the fetched byte on both halves of the 16-bit bus. RAM traffic is allowed only while the host owns the Z80 bus, as reported by a bus-grant input. A RAM access made without the bus never reaches the RAM and raises an anomaly pulse.

The block also holds three control registers. The first is a bus-request flag. The second is a reset register whose release only takes effect when a reset is pending; a release resets the FM unit again and resets the Z80. The third is a 9-bit bank register that is loaded one bit per write by shifting in from the top. It supplies the 68k-side window base for the Z80's banked area.

Top module: `z80_bus_ctrl`

## Requirements
- R1: After synchronous reset, bank_base is 0, z80_reset is 1, z80_run is 0, z80_busreq is 0, and all strobes and host_rvalid are 0.
- R2: A write to 0xA0xxxx with address bit 14 clear, made while bus_granted is 1, pulses ram_sel with sel_we=1. sel_addr carries address bits 12:0. sel_wdata carries data bits 7:0 for a byte access and bits 15:8 for a word access.
- R3: A RAM-window access made while bus_granted is 0 gives no ram_sel and pulses anomaly. If the access is a read, it returns 0xFFFF.
- R4: A granted RAM read returns {ram_rdata, ram_rdata} on host_rdata with host_rvalid high, two clock edges after the request.
- R5: An access to 0xA0xxxx with address bits 14:13 = 2'b10 pulses fm_sel, regardless of bus grant. The register select is sel_addr[1:0], the write byte is data bits 7:0, and a read returns {fm_rdata, fm_rdata}.
- R6: A read of any other 0xA0xxxx address returns 0xFFFF and pulses no strobe.
- R7: A write matching the PSG address pulses psg_sel with data bits 7:0. For a byte access the match is (addr & 0xE700F9) == 0xC00011 or (addr & 0xFF7FF9) == 0xA07F11. For a word access the masks end in F8 and the values end in 10.
- R8: An access in 0xA10000..0xA1001F pulses io_sel, and a read returns {io_rdata, io_rdata}. Address 0xA10020 pulses nothing.
- R9: A write to 0xA11100 loads z80_busreq from data bit 0 for a byte access and from data bit 8 for a word access. While no reset is pending, z80_run becomes the inverse of the new value.
- R10: A write to 0xA11200 with its active bit at 0 (bit 0 for byte, bit 8 for word) sets z80_reset, clears z80_run and pulses fm_rst_pulse alone.
- R11: A write of 1 to the active bit of 0xA11200 while z80_reset is 1 clears z80_reset, pulses both fm_rst_pulse and z80_rst_pulse, and sets z80_run to the inverse of z80_busreq. The same write while z80_reset is 0 changes nothing.
- R12: Each write whose address satisfies (addr & 0xFF7F00) == 0xA06000 shifts the 9-bit bank register right by one and loads data bit 0 into bit 8. bank_base is the register shifted left by 15. Reads of that address, and writes elsewhere, leave it unchanged.
- R13: Every strobe is a single-cycle pulse that appears one clock edge after the request, and at most one of ram_sel, fm_sel, psg_sel and io_sel is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 24 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_word | input | 1 | 1 = word access, 0 = byte access |
| host_rd | input | 1 | Read request, one cycle |
| host_wr | input | 1 | Write request, one cycle |
| bus_granted | input | 1 | Host currently owns the Z80 bus |
| ram_rdata | input | 8 | Z80 RAM read byte for sel_addr |
| fm_rdata | input | 8 | FM unit status byte |
| io_rdata | input | 8 | I/O-port read byte |
| host_rdata | output | 16 | Read return data |
| host_rvalid | output | 1 | host_rdata valid, one cycle |
| sel_addr | output | 13 | Registered address for the strobed unit |
| sel_wdata | output | 8 | Registered write byte for the strobed unit |
| sel_we | output | 1 | Strobed access is a write |
| ram_sel | output | 1 | Z80 RAM strobe |
| fm_sel | output | 1 | FM unit strobe |
| psg_sel | output | 1 | PSG strobe |
| io_sel | output | 1 | I/O-port strobe |
| anomaly | output | 1 | Pulse on RAM access without bus ownership |
| z80_busreq | output | 1 | Bus-request register |
| z80_reset | output | 1 | Z80 held in reset |
| z80_run | output | 1 | Z80 run state |
| fm_rst_pulse | output | 1 | One-cycle FM unit reset |
| z80_rst_pulse | output | 1 | One-cycle Z80 reset on release |
| bank_base | output | 24 | 68k window base of the Z80 bank |

## Verification
A wrong decode shows up one edge after the request, as the wrong strobe or a missing strobe, or as the wrong byte lane on sel_wdata. A wrong read steer shows up on host_rdata one edge later still. A corrupted reset-pending flag is more hidden. It shows only at the next release write, as missing or extra reset pulses and a wrong run state, so the bench repeats release writes in both pending states. A bank-register fault can stay invisible until a full nine writes have shifted through. For that reason bank_base is checked after a complete load, after a mirrored write, and after non-loading accesses.

// File: rtl/zsc_pkg.sv
// Shared constants and types for the Z80 subsystem bus controller.
// Assumes a 24-bit host byte address and a 16-bit host data bus.
package zsc_pkg;
    localparam int HADDR_W = 24;
    localparam int HDATA_W = 16;

    localparam logic [7:0]  AREA_PAGE   = 8'hA0;
    localparam logic [23:0] IO_BASE     = 24'hA10000;
    localparam logic [23:0] BUSREQ_ADDR = 24'hA11100;
    localparam logic [23:0] RESET_ADDR  = 24'hA11200;
    localparam logic [23:0] BANK_MASK   = 24'hFF7F00;
    localparam logic [23:0] BANK_MATCH  = 24'hA06000;

    // Decoded destination of a host access
    typedef enum logic [3:0] {
        TGT_NONE, TGT_RAM, TGT_FM, TGT_OPEN, TGT_PSG,
        TGT_IO, TGT_BUSREQ, TGT_RESET, TGT_BANK
    } tgt_e;

    // Source of a pending read return
    typedef enum logic [1:0] {RK_OPEN, RK_RAM, RK_FM, RK_IO} rkind_e;
endpackage

// File: rtl/zsc_decode.sv
// Address decoder: maps one host access to a single destination.
// Purely combinational. PSG matching is write-only and takes precedence
// over the sound area; the bank register is write-only.
module zsc_decode
    import zsc_pkg::*;
#(
    parameter int IO_AW = 5
) (
    input  logic [HADDR_W-1:0] addr,
    input  logic               word,
    input  logic               is_wr,
    output tgt_e               tgt
);
    localparam logic [HADDR_W-1:0] PSG_MASK_B = 24'hE700F9;
    localparam logic [HADDR_W-1:0] PSG_MASK_W = 24'hE700F8;
    localparam logic [HADDR_W-1:0] MIR_MASK_B = 24'hFF7FF9;
    localparam logic [HADDR_W-1:0] MIR_MASK_W = 24'hFF7FF8;

    logic psg_hit;
    logic area_hit;
    logic io_hit;

    // PSG match differs in the low address bit between byte and word access
    always_comb begin
        if (word)
            psg_hit = ((addr & PSG_MASK_W) == 24'hC00010) || ((addr & MIR_MASK_W) == 24'hA07F10);
        else
            psg_hit = ((addr & PSG_MASK_B) == 24'hC00011) || ((addr & MIR_MASK_B) == 24'hA07F11);
    end

    assign area_hit = (addr[HADDR_W-1:16] == AREA_PAGE);
    assign io_hit   = (addr[HADDR_W-1:IO_AW] == IO_BASE[HADDR_W-1:IO_AW]);

    // Priority decode into a single target
    always_comb begin
        tgt = TGT_NONE;
        if (is_wr && psg_hit)
            tgt = TGT_PSG;
        else if (area_hit) begin
            if (!addr[14])
                tgt = TGT_RAM;
            else if (addr[14:13] == 2'b10)
                tgt = TGT_FM;
            else if (is_wr && ((addr & BANK_MASK) == BANK_MATCH))
                tgt = TGT_BANK;
            else
                tgt = TGT_OPEN;
        end
        else if (io_hit)
            tgt = TGT_IO;
        else if (is_wr && addr == BUSREQ_ADDR)
            tgt = TGT_BUSREQ;
        else if (is_wr && addr == RESET_ADDR)
            tgt = TGT_RESET;
    end
endmodule

// File: rtl/zsc_ctrl_regs.sv
// Bus-request, reset and run-state registers of the Z80 subsystem.
// Assumes at most one of busreq_wr / reset_wr per cycle. Reset release
// acts only when a reset is pending and re-resets the FM unit.
module zsc_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic busreq_wr,
    input  logic reset_wr,
    input  logic ctl_bit,
    output logic z80_busreq,
    output logic z80_reset,
    output logic z80_run,
    output logic fm_rst_pulse,
    output logic z80_rst_pulse
);
    // Register updates and one-cycle reset pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z80_busreq    <= 1'b0;
            z80_reset     <= 1'b1;
            z80_run       <= 1'b0;
            fm_rst_pulse  <= 1'b0;
            z80_rst_pulse <= 1'b0;
        end else begin
            fm_rst_pulse  <= 1'b0;
            z80_rst_pulse <= 1'b0;
            if (busreq_wr) begin
                z80_busreq <= ctl_bit;
                if (!z80_reset)
                    z80_run <= ~ctl_bit;
            end
            if (reset_wr) begin
                if (!ctl_bit) begin
                    z80_reset    <= 1'b1;
                    z80_run      <= 1'b0;
                    fm_rst_pulse <= 1'b1;
                end else if (z80_reset) begin
                    z80_reset     <= 1'b0;
                    z80_run       <= ~z80_busreq;
                    fm_rst_pulse  <= 1'b1;
                    z80_rst_pulse <= 1'b1;
                end
            end
        end
    end

    // R10
    reset_kicks_fm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(z80_reset) |-> fm_rst_pulse);
    // R10
    reset_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z80_reset |-> !z80_run);
    // R11
    release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z80_rst_pulse |-> ($fell(z80_reset) && fm_rst_pulse));
endmodule

// File: rtl/zsc_bank_reg.sv
// Serially loaded bank register: each load shifts right and inserts the
// new bit at the top. The window base is the register scaled by 2^BANK_SHIFT.
module zsc_bank_reg #(
    parameter int BANK_W     = 9,
    parameter int BANK_SHIFT = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bank_wr,
    input  logic                         load_bit,
    output logic [BANK_W+BANK_SHIFT-1:0] bank_base
);
    localparam int BASE_W = BANK_W + BANK_SHIFT;

    logic [BANK_W-1:0] bank_q;

    // Shift in one bit from the top per load
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (bank_wr)
            bank_q <= {load_bit, bank_q[BANK_W-1:1]};
    end

    assign bank_base = BASE_W'({bank_q, {BANK_SHIFT{1'b0}}});

    // R12
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr |=> $stable(bank_q));
endmodule

// File: rtl/z80_bus_ctrl.sv
// Host-side controller of the Z80 sound subsystem: decodes host accesses,
// registers single-cycle strobes to RAM/FM/PSG/I-O units, gates RAM on bus
// ownership, returns read data two edges after the request, and holds the
// control and bank registers. Assumes unit read data is valid in the cycle
// its strobe is high.
module z80_bus_ctrl
    import zsc_pkg::*;
#(
    parameter int RAM_AW     = 13,
    parameter int IO_AW      = 5,
    parameter int BANK_W     = 9,
    parameter int BANK_SHIFT = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [23:0]                  host_addr,
    input  logic [15:0]                  host_wdata,
    input  logic                         host_word,
    input  logic                         host_rd,
    input  logic                         host_wr,
    input  logic                         bus_granted,
    input  logic [7:0]                   ram_rdata,
    input  logic [7:0]                   fm_rdata,
    input  logic [7:0]                   io_rdata,
    output logic [15:0]                  host_rdata,
    output logic                         host_rvalid,
    output logic [RAM_AW-1:0]            sel_addr,
    output logic [7:0]                   sel_wdata,
    output logic                         sel_we,
    output logic                         ram_sel,
    output logic                         fm_sel,
    output logic                         psg_sel,
    output logic                         io_sel,
    output logic                         anomaly,
    output logic                         z80_busreq,
    output logic                         z80_reset,
    output logic                         z80_run,
    output logic                         fm_rst_pulse,
    output logic                         z80_rst_pulse,
    output logic [BANK_W+BANK_SHIFT-1:0] bank_base
);
    tgt_e   tgt;
    rkind_e rd_kind;
    logic   rd_pend;
    logic   acc;
    logic   ctl_bit;
    logic   wbyte_hi;

    zsc_decode #(.IO_AW(IO_AW)) u_decode (
        .addr  (host_addr),
        .word  (host_word),
        .is_wr (host_wr),
        .tgt   (tgt)
    );

    assign acc      = host_rd | host_wr;
    assign ctl_bit  = host_word ? host_wdata[8] : host_wdata[0];
    assign wbyte_hi = (tgt == TGT_RAM) && host_word;

    zsc_ctrl_regs u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .busreq_wr     (host_wr && tgt == TGT_BUSREQ),
        .reset_wr      (host_wr && tgt == TGT_RESET),
        .ctl_bit       (ctl_bit),
        .z80_busreq    (z80_busreq),
        .z80_reset     (z80_reset),
        .z80_run       (z80_run),
        .fm_rst_pulse  (fm_rst_pulse),
        .z80_rst_pulse (z80_rst_pulse)
    );

    zsc_bank_reg #(.BANK_W(BANK_W), .BANK_SHIFT(BANK_SHIFT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_wr   (host_wr && tgt == TGT_BANK),
        .load_bit  (host_wdata[0]),
        .bank_base (bank_base)
    );

    // Register the strobe, address, write byte and pending read kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_addr  <= '0;
            sel_wdata <= '0;
            sel_we    <= 1'b0;
            ram_sel   <= 1'b0;
            fm_sel    <= 1'b0;
            psg_sel   <= 1'b0;
            io_sel    <= 1'b0;
            anomaly   <= 1'b0;
            rd_pend   <= 1'b0;
            rd_kind   <= RK_OPEN;
        end else begin
            ram_sel <= 1'b0;
            fm_sel  <= 1'b0;
            psg_sel <= 1'b0;
            io_sel  <= 1'b0;
            anomaly <= 1'b0;
            rd_pend <= 1'b0;
            if (acc) begin
                sel_addr  <= host_addr[RAM_AW-1:0];
                sel_wdata <= wbyte_hi ? host_wdata[15:8] : host_wdata[7:0];
                sel_we    <= host_wr;
                rd_pend   <= host_rd && (tgt inside {TGT_RAM, TGT_FM, TGT_OPEN, TGT_IO});
                rd_kind   <= RK_OPEN;
                case (tgt)
                    TGT_RAM: begin
                        if (bus_granted) begin
                            ram_sel <= 1'b1;
                            rd_kind <= RK_RAM;
                        end else
                            anomaly <= 1'b1;
                    end
                    TGT_FM: begin
                        fm_sel  <= 1'b1;
                        rd_kind <= RK_FM;
                    end
                    TGT_PSG: psg_sel <= 1'b1;
                    TGT_IO: begin
                        io_sel  <= 1'b1;
                        rd_kind <= RK_IO;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Capture the unit's read byte and return it on both halves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= rd_pend;
            if (rd_pend) begin
                case (rd_kind)
                    RK_RAM:  host_rdata <= {ram_rdata, ram_rdata};
                    RK_FM:   host_rdata <= {fm_rdata, fm_rdata};
                    RK_IO:   host_rdata <= {io_rdata, io_rdata};
                    default: host_rdata <= '1;
                endcase
            end
        end
    end

    // R13
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, fm_sel, psg_sel, io_sel}));
    // R3
    ram_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> $past(bus_granted));
    // R3
    anomaly_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        anomaly |-> !ram_sel);
    // R4
    rvalid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_rd, 2));
endmodule

// File: tb/test_z80_bus_ctrl.sv
module test_z80_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_word = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic        bus_granted = 1'b0;
    logic [7:0]  ram_rdata;
    logic [7:0]  fm_rdata = 8'hC3;
    logic [7:0]  io_rdata = 8'h96;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic [12:0] sel_addr;
    logic [7:0]  sel_wdata;
    logic        sel_we, ram_sel, fm_sel, psg_sel, io_sel, anomaly;
    logic        z80_busreq, z80_reset, z80_run, fm_rst_pulse, z80_rst_pulse;
    logic [23:0] bank_base;

    always #10 clk = ~clk;

    // RAM model: read byte is a fixed function of the strobed address
    assign ram_rdata = sel_addr[7:0] ^ 8'h5A;

    z80_bus_ctrl i_z80_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_word(host_word), .host_rd(host_rd), .host_wr(host_wr),
        .bus_granted(bus_granted), .ram_rdata(ram_rdata), .fm_rdata(fm_rdata),
        .io_rdata(io_rdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .sel_addr(sel_addr), .sel_wdata(sel_wdata), .sel_we(sel_we),
        .ram_sel(ram_sel), .fm_sel(fm_sel), .psg_sel(psg_sel), .io_sel(io_sel),
        .anomaly(anomaly), .z80_busreq(z80_busreq), .z80_reset(z80_reset),
        .z80_run(z80_run), .fm_rst_pulse(fm_rst_pulse),
        .z80_rst_pulse(z80_rst_pulse), .bank_base(bank_base)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Snapshots: s_* after the first edge, r_* after the second
    logic [3:0]  s_sel;
    logic        s_we, s_anom, s_fmr, s_z80r;
    logic [12:0] s_addr;
    logic [7:0]  s_wdata;
    logic        r_rv, l_any;
    logic [15:0] r_rd;

    task automatic access(input logic rd, input logic wr, input logic word, input logic gnt,
                          input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        host_rd = rd; host_wr = wr; host_word = word; host_addr = a;
        host_wdata = d; bus_granted = gnt;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        s_sel = {ram_sel, fm_sel, psg_sel, io_sel};
        s_we = sel_we; s_anom = anomaly; s_addr = sel_addr; s_wdata = sel_wdata;
        s_fmr = fm_rst_pulse; s_z80r = z80_rst_pulse;
        @(negedge clk);
        r_rv = host_rvalid; r_rd = host_rdata;
        l_any = ram_sel | fm_sel | psg_sel | io_sel | anomaly | fm_rst_pulse | z80_rst_pulse;
    endtask

    typedef struct packed {
        logic        rd;
        logic        word;
        logic        gnt;
        logic [23:0] addr;
        logic [15:0] wdata;
        logic [2:0]  tgt;     // 0 none, 1 RAM, 2 FM, 3 PSG, 4 I/O
        logic        anom;
        logic [7:0]  wbyte;
        logic [15:0] rdata;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 24'hA00123, 16'h00AB, 3'd1, 1'b0, 8'hAB, 16'h0000, 4'd2},  // R2 byte lane
        '{1'b0, 1'b1, 1'b1, 24'hA01FFE, 16'hCD34, 3'd1, 1'b0, 8'hCD, 16'h0000, 4'd2},  // R2 word upper byte
        '{1'b0, 1'b0, 1'b0, 24'hA00040, 16'h0077, 3'd0, 1'b1, 8'h00, 16'h0000, 4'd3},  // R3 write dropped
        '{1'b1, 1'b0, 1'b1, 24'hA00012, 16'h0000, 3'd1, 1'b0, 8'h00, 16'h4848, 4'd4},  // R4 duplicated byte
        '{1'b1, 1'b0, 1'b0, 24'hA00012, 16'h0000, 3'd0, 1'b1, 8'h00, 16'hFFFF, 4'd3},  // R3 read without bus
        '{1'b0, 1'b0, 1'b1, 24'hA04002, 16'h0055, 3'd2, 1'b0, 8'h55, 16'h0000, 4'd5},  // R5 FM write
        '{1'b1, 1'b0, 1'b0, 24'hA04001, 16'h0000, 3'd2, 1'b0, 8'h00, 16'hC3C3, 4'd5},  // R5 FM read, no grant
        '{1'b1, 1'b0, 1'b1, 24'hA07000, 16'h0000, 3'd0, 1'b0, 8'h00, 16'hFFFF, 4'd6},  // R6 open read
        '{1'b1, 1'b1, 1'b1, 24'hA0E000, 16'h0000, 3'd0, 1'b0, 8'h00, 16'hFFFF, 4'd6},  // R6 open word read
        '{1'b0, 1'b0, 1'b1, 24'hC00011, 16'h009F, 3'd3, 1'b0, 8'h9F, 16'h0000, 4'd7},  // R7 PSG
        '{1'b0, 1'b0, 1'b1, 24'hA07F11, 16'h0011, 3'd3, 1'b0, 8'h11, 16'h0000, 4'd7},  // R7 PSG mirror
        '{1'b0, 1'b1, 1'b1, 24'hC00010, 16'h0022, 3'd3, 1'b0, 8'h22, 16'h0000, 4'd7},  // R7 PSG word
        '{1'b0, 1'b0, 1'b1, 24'hC80011, 16'h0066, 3'd3, 1'b0, 8'h66, 16'h0000, 4'd7},  // R7 PSG masked alias
        '{1'b0, 1'b0, 1'b1, 24'hA1001E, 16'h0033, 3'd4, 1'b0, 8'h33, 16'h0000, 4'd8},  // R8 I/O top
        '{1'b1, 1'b0, 1'b1, 24'hA10004, 16'h0000, 3'd4, 1'b0, 8'h00, 16'h9696, 4'd8},  // R8 I/O read
        '{1'b0, 1'b0, 1'b1, 24'hA10020, 16'h0044, 3'd0, 1'b0, 8'h00, 16'h0000, 4'd8}   // R8 outside window
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 bank_base", bank_base, 24'h0);
        check("R1 z80_reset", z80_reset, 1'b1);
        check("R1 z80_run", z80_run, 1'b0);
        check("R1 z80_busreq", z80_busreq, 1'b0);
        check("R1 strobes/rvalid", {ram_sel, fm_sel, psg_sel, io_sel, anomaly, host_rvalid}, 6'b0);

        // Decode table (R2..R8, R13)
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [3:0] exp_sel;
            v = VECS[i];
            access(v.rd, !v.rd, v.word, v.gnt, v.addr, v.wdata);
            case (v.tgt)
                3'd1: exp_sel = 4'b1000;
                3'd2: exp_sel = 4'b0100;
                3'd3: exp_sel = 4'b0010;
                3'd4: exp_sel = 4'b0001;
                default: exp_sel = 4'b0000;
            endcase
            check($sformatf("R%0d strobe vec%0d", v.req, i), s_sel, exp_sel);
            check($sformatf("R%0d anomaly vec%0d", v.req, i), s_anom, v.anom);
            if (v.tgt != 3'd0) begin
                check($sformatf("R%0d sel_we vec%0d", v.req, i), s_we, !v.rd);
                if (v.tgt != 3'd3)
                    check($sformatf("R%0d sel_addr vec%0d", v.req, i), s_addr, v.addr[12:0]);
                if (!v.rd)
                    check($sformatf("R%0d sel_wdata vec%0d", v.req, i), s_wdata, v.wbyte);
            end
            check($sformatf("R%0d rvalid vec%0d", v.req, i), r_rv, v.rd);
            if (v.rd)
                check($sformatf("R%0d rdata vec%0d", v.req, i), r_rd, v.rdata);
            // R13 pulses last one cycle
            check($sformatf("R13 pulse width vec%0d", i), l_any, 1'b0);
        end

        // R9 bus-request bit selection, while reset is pending
        access(1'b0, 1'b1, 1'b0, 1'b1, 24'hA11100, 16'h0001);
        check("R9 byte bit0 set", z80_busreq, 1'b1);
        check("R9 run held in reset", z80_run, 1'b0);
        access(1'b0, 1'b1, 1'b1, 1'b1, 24'hA11100, 16'h0001);
        check("R9 word uses bit8 clear", z80_busreq, 1'b0);
        access(1'b0, 1'b1, 1'b1, 1'b1, 24'hA11100, 16'h0100);
        check("R9 word bit8 set", z80_busreq, 1'b1);
        access(1'b0, 1'b1, 1'b0, 1'b1, 24'hA11100, 16'h0100);
        check("R9 byte ignores bit8", z80_busreq, 1'b0);
        access(1'b0, 1'b1, 1'b0, 1'b1, 24'hA11100, 16'h0001);

        // R11 release with reset pending
        access(1'b0, 1'b1, 1'b0, 1'b1, 24'hA11200, 16'h0001);
        check("R11 pulses", {s_fmr, s_z80r}, 2'b11);
        check("R11 reset cleared", z80_reset, 1'b0);
        check("R11 run=~busreq", z80_run, 1'b0);
        access(1'b0, 1'b1, 1'b0, 1'b1, 24'hA11100, 16'h0000);
        check("R9 run follows busreq", z80_run, 1'b1);
        access(1'b0, 1'b1, 1'b0, 1'b1, 24'hA11200, 16'h0001);
        check("R11 no pulses when not pending", {s_fmr, s_z80r}, 2'b00);
        check("R11 state unchanged", {z80_reset, z80_run}, 2'b01);

        // R10 assert by word write (bit 8 = 0)
        access(1'b0, 1'b1, 1'b1, 1'b1, 24'hA11200, 16'h0001);
        check("R10 fm pulse only", {s_fmr, s_z80r}, 2'b10);
        check("R10 reset and run", {z80_reset, z80_run}, 2'b10);
        access(1'b0, 1'b1, 1'b1, 1'b1, 24'hA11200, 16'h0100);
        check("R11 word release pulses", {s_fmr, s_z80r}, 2'b11);
        check("R11 word release state", {z80_reset, z80_run}, 2'b01);
        access(1'b0, 1'b1, 1'b0, 1'b1, 24'hA11200, 16'h0100);
        check("R10 byte bit0 asserts", {z80_reset, z80_run}, 2'b10);

        // R12 bank register serial load
        for (int b = 0; b < 9; b++) begin
            logic [8:0] pat;
            pat = 9'h14D;
            access(1'b0, 1'b1, 1'b0, 1'b1, 24'hA06000, {15'b0, pat[b]});
        end
        check("R12 full load", bank_base, 24'hA68000);
        access(1'b0, 1'b1, 1'b1, 1'b1, 24'hA0E000, 16'hFFFE);
        check("R12 mirrored shift", bank_base, 24'h530000);
        access(1'b0, 1'b1, 1'b0, 1'b1, 24'hA06100, 16'h0001);
        check("R12 non-bank write", bank_base, 24'h530000);
        access(1'b1, 1'b0, 1'b0, 1'b1, 24'hA06000, 16'h0001);
        check("R12 read no shift", bank_base, 24'h530000);
        check("R6 bank read open", r_rd, 16'hFFFF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule